// File: doc/BRIEF.md
# Short-Address Bus Slave Front End

This block sits between a 16-bit short I/O bus and the registers of a card that answers in a 1 KB window. It compares the upper six address bits with a base-address strap and checks the address-modifier code against the codes a strap allows. When the address strobe is valid and the card is selected, it waits for a data strobe and then times the transfer acknowledge with a shift-register delay. It reports the word offset and byte lanes to the register blocks behind it, and returns read data on the bus.

The first 64 bytes of the window hold an identification ROM on the odd bytes. It contains a fixed signature, a three-character vendor code, a four-character model number padded with three blanks, and the window size in kilobytes as an ASCII digit. Other offsets are claimed by neighbouring blocks through `ext_hit`. An offset that nobody claims reads as all ones. A long-word access gets a bus error and no acknowledge. The bus handshake is the strobe protocol itself, with no separate valid/ready: the master holds the strobes until it sees an acknowledge or an error, and releasing both data strobes ends the cycle. That release is the only form of back-pressure.

Top module: `a16_slave_front`

## Requirements
- R1: `card_sel` is 1 only when `addr[15:10]` equals `base_strap`, and only then can an acknowledge or bus error appear.
- R2: Modifier code 0x2D is always accepted. Code 0x29 is accepted only while `am29_en` is 1. Every other code leaves `card_sel` at 0.
- R3: `card_sel` is 0 whenever `as_n` is high.
- R4: With the card selected and a data strobe low before clock edge 1, `dtack` is 0 up to edge ACK_TAP−1 and 1 after edge ACK_TAP (default ACK_TAP = 3).
- R5: With `lword_n` low on a selected access, `berr` is 1 after the first edge and `dtack` never rises.
- R6: When both data strobes go high, `dtack` and `berr` fall in the same cycle. The timer restarts from zero, so a following access again waits the full ACK_TAP edges.
- R7: A read at word index i < 32 (byte offset 2i+1) returns 0xFF on bits 15:8. Bits 7:0 carry, in order: "VMEID" for i = 0..4, the vendor code for 5..7, the model code and three blanks (0x20) for 8..14, ASCII '0'+WIN_KB for 15, and 0xFF for 16..31.
- R8: A read at byte offset 0x40 or above returns `ext_rdata` when `ext_hit` is 1 and 0xFFFF otherwise.
- R9: `rd_data` is nonzero only while `dtack` is 1 on a read (`write_n` high). `oe_hi` follows `ds1_n` low (bits 15:8) and `oe_lo` follows `ds0_n` low (bits 7:0), both only during that acknowledged read.
- R10: On a write, `reg_wr` is a single-cycle pulse in the first acknowledged cycle. At that time `reg_word` equals `addr[9:1]` and `lane_hi`/`lane_lo` reflect `ds1_n`/`ds0_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 15 | Bus address bits 15:1 |
| am | input | 6 | Address-modifier code |
| as_n | input | 1 | Address strobe, active low |
| ds0_n | input | 1 | Odd-byte (bits 7:0) data strobe, active low |
| ds1_n | input | 1 | Even-byte (bits 15:8) data strobe, active low |
| lword_n | input | 1 | Long-word request, active low |
| write_n | input | 1 | 1 = read, 0 = write |
| base_strap | input | 6 | Window base, compared with addr[15:10] |
| am29_en | input | 1 | Strap: also accept modifier 0x29 |
| ext_hit | input | 1 | A register block claims the current offset |
| ext_rdata | input | 16 | Read data from the claiming block |
| card_sel | output | 1 | Card decoded with valid address strobe |
| dtack | output | 1 | Transfer acknowledge |
| berr | output | 1 | Bus error for long-word access |
| rd_data | output | 16 | Read data, zero unless acknowledged read |
| oe_hi | output | 1 | Drive bits 15:8 |
| oe_lo | output | 1 | Drive bits 7:0 |
| reg_word | output | 9 | Word offset within the window |
| lane_hi | output | 1 | Even byte lane selected |
| lane_lo | output | 1 | Odd byte lane selected |
| reg_rd | output | 1 | Read in progress to an external offset |
| reg_wr | output | 1 | One-cycle write strobe |

## Verification
Random accesses mix matching and non-matching base addresses, the three classes of modifier code, both settings of the 0x29 strap, byte and word strobe patterns, and occasional long-word requests. Together they separate a wrong address compare from a wrong modifier filter and a wrong lane mapping. Each access is followed edge by edge, so an acknowledge that comes one cycle early or late is seen apart from a missing one. The ROM, undefined and claimed offsets are each read, which tells a bad ROM entry apart from a wrong fill value. Directed cases cover a strobe with the address strobe high, a strobe released in the middle of the delay, and back-to-back accesses, which show whether the timer clears.

// File: rtl/a16s_pkg.sv
package a16s_pkg;
  localparam logic [5:0] AM_SUPER = 6'h2D;
  localparam logic [5:0] AM_USER  = 6'h29;
  localparam int unsigned ROM_WORDS = 32;
  localparam logic [15:0] FILL_WORD = 16'hFFFF;
  typedef logic [8:0] word_idx_t;
endpackage

// File: rtl/slv_addr_match.sv
module slv_addr_match
  import a16s_pkg::*;
#(
  parameter int unsigned BASE_W = 6
) (
  input  logic [BASE_W-1:0] addr_hi,
  input  logic [5:0]        am,
  input  logic              as_n,
  input  logic [BASE_W-1:0] base_strap,
  input  logic              am29_en,
  output logic              card_sel
);
  logic am_ok;
  always_comb begin
    am_ok    = (am == AM_SUPER) || (am29_en && (am == AM_USER));
    card_sel = !as_n && am_ok && (addr_hi == base_strap);
  end
endmodule

// File: rtl/slv_ack_timer.sv
module slv_ack_timer #(
  parameter int unsigned ACK_TAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lword_n,
  output logic dtack,
  output logic berr
);
  localparam int unsigned SR_W = (ACK_TAP < 1) ? 1 : ACK_TAP;

  logic [SR_W-1:0] sr;

  generate
    if (SR_W == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sr <= '0;
        else if (!start) sr <= '0;
        else             sr <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sr <= '0;
        else if (!start) sr <= '0;
        else             sr <= {sr[SR_W-2:0], 1'b1};
      end
    end
  endgenerate

  always_comb begin
    dtack = start && lword_n && sr[SR_W-1];
    berr  = start && !lword_n && sr[0];
  end

  // R5
  berr_first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !lword_n) |=> (berr || !start || lword_n));
endmodule

// File: rtl/slv_id_rom.sv
module slv_id_rom #(
  parameter logic [23:0] VENDOR_TAG = 24'h515253,
  parameter logic [31:0] MODEL_TAG  = 32'h37333130,
  parameter int unsigned WIN_KB     = 1
) (
  input  logic [4:0] idx,
  output logic [7:0] id_byte
);
  localparam logic [7:0] KB_CHAR = 8'(8'h30 + WIN_KB);

  always_comb begin
    case (idx)
      5'd0:  id_byte = 8'h56;
      5'd1:  id_byte = 8'h4D;
      5'd2:  id_byte = 8'h45;
      5'd3:  id_byte = 8'h49;
      5'd4:  id_byte = 8'h44;
      5'd5:  id_byte = VENDOR_TAG[23:16];
      5'd6:  id_byte = VENDOR_TAG[15:8];
      5'd7:  id_byte = VENDOR_TAG[7:0];
      5'd8:  id_byte = MODEL_TAG[31:24];
      5'd9:  id_byte = MODEL_TAG[23:16];
      5'd10: id_byte = MODEL_TAG[15:8];
      5'd11: id_byte = MODEL_TAG[7:0];
      5'd12, 5'd13, 5'd14: id_byte = 8'h20;
      5'd15: id_byte = KB_CHAR;
      default: id_byte = 8'hFF;
    endcase
  end
endmodule

// File: rtl/a16_slave_front.sv
module a16_slave_front
  import a16s_pkg::*;
#(
  parameter int unsigned ACK_TAP    = 3,
  parameter logic [23:0] VENDOR_TAG = 24'h515253,
  parameter logic [31:0] MODEL_TAG  = 32'h37333130,
  parameter int unsigned WIN_KB     = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:1] addr,
  input  logic [5:0]  am,
  input  logic        as_n,
  input  logic        ds0_n,
  input  logic        ds1_n,
  input  logic        lword_n,
  input  logic        write_n,
  input  logic [5:0]  base_strap,
  input  logic        am29_en,
  input  logic        ext_hit,
  input  logic [15:0] ext_rdata,
  output logic        card_sel,
  output logic        dtack,
  output logic        berr,
  output logic [15:0] rd_data,
  output logic        oe_hi,
  output logic        oe_lo,
  output logic [8:0]  reg_word,
  output logic        lane_hi,
  output logic        lane_lo,
  output logic        reg_rd,
  output logic        reg_wr
);
  logic       start;
  logic       rom_zone;
  logic [7:0] id_byte;
  logic [15:0] word_mux;
  logic       rd_ack;
  logic       dtack_q;

  slv_addr_match #(.BASE_W(6)) u_match (
    .addr_hi(addr[15:10]), .am(am), .as_n(as_n),
    .base_strap(base_strap), .am29_en(am29_en), .card_sel(card_sel)
  );

  assign start = card_sel && (!ds0_n || !ds1_n);

  slv_ack_timer #(.ACK_TAP(ACK_TAP)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .lword_n(lword_n),
    .dtack(dtack), .berr(berr)
  );

  slv_id_rom #(.VENDOR_TAG(VENDOR_TAG), .MODEL_TAG(MODEL_TAG), .WIN_KB(WIN_KB)) u_rom (
    .idx(addr[5:1]), .id_byte(id_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dtack_q <= 1'b0;
    else        dtack_q <= dtack;
  end

  always_comb begin
    rom_zone = (addr[9:6] == 4'd0);
    reg_word = word_idx_t'(addr[9:1]);
    lane_hi  = !ds1_n;
    lane_lo  = !ds0_n;
    if (rom_zone)     word_mux = {8'hFF, id_byte};
    else if (ext_hit) word_mux = ext_rdata;
    else              word_mux = FILL_WORD;
    rd_ack  = dtack && write_n;
    rd_data = rd_ack ? word_mux : 16'h0000;
    oe_hi   = rd_ack && lane_hi;
    oe_lo   = rd_ack && lane_lo;
    reg_rd  = start && write_n && lword_n && !rom_zone;
    reg_wr  = dtack && !dtack_q && !write_n;
  end

  // R1
  base_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dtack || berr) |-> (addr[15:10] == base_strap));
  // R3
  strobe_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> !(dtack || berr));
  // R5
  no_lw_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dtack |-> lword_n);
  // R6
  release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ds0_n && ds1_n) |-> !(dtack || berr));
  // R9
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_hi || oe_lo) |-> (dtack && write_n));
  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
endmodule

// File: tb/a16_slave_front_bench.sv
`timescale 1ns/1ps
module a16_slave_front_bench;
  localparam int TAP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] addr = '0;
  logic [5:0]  am = '0;
  logic        as_n = 1'b1, ds0_n = 1'b1, ds1_n = 1'b1;
  logic        lword_n = 1'b1, write_n = 1'b1;
  logic [5:0]  base_strap = 6'h00;
  logic        am29_en = 1'b0, ext_hit = 1'b0;
  logic [15:0] ext_rdata = '0;
  logic        card_sel, dtack, berr, oe_hi, oe_lo, lane_hi, lane_lo, reg_rd, reg_wr;
  logic [15:0] rd_data;
  logic [8:0]  reg_word;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  a16_slave_front #(.ACK_TAP(TAP)) u_a16_slave_front (
    .clk(clk), .rst_n(rst_n), .addr(addr), .am(am), .as_n(as_n),
    .ds0_n(ds0_n), .ds1_n(ds1_n), .lword_n(lword_n), .write_n(write_n),
    .base_strap(base_strap), .am29_en(am29_en), .ext_hit(ext_hit),
    .ext_rdata(ext_rdata), .card_sel(card_sel), .dtack(dtack), .berr(berr),
    .rd_data(rd_data), .oe_hi(oe_hi), .oe_lo(oe_lo), .reg_word(reg_word),
    .lane_hi(lane_hi), .lane_lo(lane_lo), .reg_rd(reg_rd), .reg_wr(reg_wr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rom_exp(input int i);
    string s = "VMEIDQRS7310   1";
    if (i < 16) return s[i];
    return 8'hFF;
  endfunction

  function automatic logic [15:0] read_exp(input logic [15:1] a, input logic eh, input logic [15:0] ed);
    if (a[9:6] == 4'd0) return {8'hFF, rom_exp(int'(a[5:1]))};
    if (eh) return ed;
    return 16'hFFFF;
  endfunction

  function automatic logic hit_exp(input logic [15:1] a, input logic [5:0] m);
    return (a[15:10] == base_strap) && ((m == 6'h2D) || (am29_en && m == 6'h29));
  endfunction

  // full access: inputs driven 1ns after a rising edge, sampled at falling edges
  task automatic access(input logic [15:1] a, input logic [5:0] m, input logic lw,
                        input logic wr, input logic d0, input logic d1, input int rel_at);
    logic h;
    @(posedge clk); #1;
    addr = a; am = m; lword_n = lw; write_n = wr; as_n = 1'b0; ds0_n = d0; ds1_n = d1;
    h = hit_exp(a, m);
    @(negedge clk);
    chk("R1/R2 card_sel", card_sel, h);
    chk("R4 dtack before edge 1", dtack, 0);
    for (int k = 1; k <= TAP + 1; k++) begin
      @(negedge clk);
      if (k == rel_at) begin
        ds0_n = 1'b1; ds1_n = 1'b1; #0.5;
        chk("R6 dtack drops on release", dtack, 0);
        chk("R6 berr drops on release", berr, 0);
        break;
      end
      chk("R4/R5 dtack timing", dtack, h && lw && (k >= TAP));
      chk("R5 berr", berr, h && !lw);
      if (k == TAP) begin
        chk("R10 reg_wr pulse", reg_wr, h && lw && !wr);
        if (h && lw && wr) begin
          chk("R7/R8 read data", rd_data, read_exp(a, ext_hit, ext_rdata));
          chk("R9 oe_hi lane", oe_hi, !d1);
          chk("R9 oe_lo lane", oe_lo, !d0);
        end else begin
          chk("R9 no drive", {oe_hi, oe_lo, rd_data}, 0);
        end
        if (h && lw && !wr) begin
          chk("R10 reg_word", reg_word, a[9:1]);
          chk("R10 lanes", {lane_hi, lane_lo}, {!d1, !d0});
        end
      end
      if (k == TAP + 1) chk("R10 single pulse", reg_wr, 0);
    end
    ds0_n = 1'b1; ds1_n = 1'b1;
    @(negedge clk); as_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        #900000;
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog expired");
          $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
          $finish;
        end
      end
    join_none
  end

  initial begin
    logic [15:1] a;
    logic [5:0] m;
    int r;
    void'($urandom(32'd4711));
    base_strap = 6'h2A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset state", {card_sel, dtack, berr, reg_wr, oe_hi, oe_lo}, 0);
    rst_n = 1'b1;

    // R3: strobes with address strobe high
    @(posedge clk); #1;
    addr = {6'h2A, 9'd3}; am = 6'h2D; ds0_n = 1'b0; as_n = 1'b1;
    repeat (TAP + 1) @(negedge clk);
    chk("R3 no select without as", {card_sel, dtack}, 0);
    ds0_n = 1'b1;

    // R7 ROM walk
    for (int i = 0; i < 32; i++) access({6'h2A, 4'd0, 5'(i)}, 6'h2D, 1, 1, 0, 0, 0);
    // R2 modifier strap
    am29_en = 1'b0; access({6'h2A, 9'h80}, 6'h29, 1, 1, 0, 0, 0);
    am29_en = 1'b1; access({6'h2A, 9'h80}, 6'h29, 1, 1, 0, 0, 0);
    access({6'h2A, 9'h80}, 6'h3D, 1, 1, 0, 0, 0);
    // R8 undefined vs claimed
    ext_hit = 1'b0; access({6'h2A, 9'h1F0}, 6'h2D, 1, 1, 0, 0, 0);
    ext_hit = 1'b1; ext_rdata = 16'h1234; access({6'h2A, 9'h80}, 6'h2D, 1, 1, 0, 1, 0);
    // R5 long word, R6 early release then full-delay access
    access({6'h2A, 9'h81}, 6'h2D, 0, 0, 0, 0, 0);
    access({6'h2A, 9'h81}, 6'h2D, 1, 0, 0, 0, TAP - 1);
    access({6'h2A, 9'h81}, 6'h2D, 1, 0, 1, 0, 0);
    // R1 base mismatch
    access({6'h15, 9'h81}, 6'h2D, 1, 1, 0, 0, 0);

    for (int n = 0; n < 200; n++) begin
      r = int'($urandom % 4);
      a = 15'($urandom);
      if (r != 0) a[15:10] = base_strap;
      r = int'($urandom % 3);
      m = (r == 0) ? 6'h2D : (r == 1) ? 6'h29 : 6'($urandom);
      am29_en = 1'($urandom);
      ext_hit = 1'($urandom);
      ext_rdata = 16'($urandom);
      r = int'($urandom % 3);
      access(a, m, ($urandom % 8) != 0, 1'($urandom), r == 1, r == 2, 0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule